// File: doc/BRIEF.md
# Relocatable RAM and EEPROM Window Decoder

This block turns a 16-bit CPU address into two chip selects, one for an on-chip RAM array and one for an EEPROM array, together with the byte offset into whichever array is hit. Each array's position in the address map comes from its own 8-bit placement register. The five upper bits of each register give address bits 15..11 of the requested base. Bit 0 is the alignment bit for RAM and the enable bit for EEPROM.

The RAM size is a build-time parameter: 2, 4, 8, 12 or 16 KB. A power-of-two RAM sits on a boundary equal to its own size. The 12 KB RAM claims a 16 KB slot, and its alignment bit leaves the 4 KB gap either at the top or at the bottom of that slot. The EEPROM size is a power-of-two parameter, and its base is aligned to that size. If the two windows overlap, RAM wins.

The decode is combinational from the address and the stored register values. The registers change on the clock edge that samples a write strobe.

Top module: `memwin_decoder`

## Requirements
- R1: After reset the RAM placement register reads 0x09 and the EEPROM placement register reads 0x00, so the EEPROM is disabled. With the default 12 KB RAM, the RAM then covers 0x1000..0x3FFF.
- R2: A write with `wr_en`=1 loads `wr_data` into the RAM register (`wr_to_ee`=0) or into the EEPROM register (`wr_to_ee`=1). The new value is visible after the next rising clock edge and not before it. Only bits 7..3 and bit 0 are stored, and bits 2..1 read back as 0. Without `wr_en` both registers hold their values.
- R3: EEPROM register bits 7..3 give address bits 15..11 of the EEPROM base, and bits below the EEPROM size are ignored. With a 4 KB EEPROM, 0x01 maps it to 0x0000..0x0FFF, 0x21 maps it to 0x2000..0x2FFF, and 0x29 also maps it to 0x2000.
- R4: `ee_sel` is 0 for every address while EEPROM register bit 0 is 0.
- R5: A RAM of 2, 4, 8 or 16 KB starts at the register base rounded down to a multiple of its size, and the alignment bit (bit 0) has no effect on it. For example, an 8 KB RAM with register value 0x49 covers 0x4000..0x5FFF.
- R6: A 12 KB RAM occupies the 16 KB slot chosen by register bits 7..6. With bit 0 at 0 it covers the lower 12 KB of the slot, and with bit 0 at 1 it covers the upper 12 KB.
- R7: The register value 0x39 puts the last RAM byte at 0x3FFF for every supported size.
- R8: Where the two windows overlap, only `ram_sel` is asserted.
- R9: Each offset equals the address minus the start of its window while that array's select is 1, and is 0 otherwise.
- R10: The selects and offsets follow `addr` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the placement registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for a placement register |
| wr_to_ee | input | 1 | Write target: 0 selects the RAM register, 1 selects the EEPROM register |
| wr_data | input | 8 | Value to store |
| addr | input | 16 | CPU address to decode |
| ram_cfg_q | output | 8 | RAM placement register readback |
| ee_cfg_q | output | 8 | EEPROM placement register readback |
| ram_sel | output | 1 | Address falls in the RAM window |
| ram_off | output | RAM_OFF_W (14) | Offset into the RAM |
| ee_sel | output | 1 | Address falls in the EEPROM window and not in the RAM window |
| ee_off | output | EE_OFF_W (12) | Offset into the EEPROM |

## Verification
Selects and offsets are due in the same cycle the address is applied. The scoreboard monitor therefore compares them at the falling edge that follows each address change, which is made just after a rising edge. Register contents are due one rising edge after the strobe. Each write also pushes a probe for the strobe cycle itself that still expects the old decode, and the new decode is expected only from the following cycle. A second instance built with an 8 KB RAM runs on the same stimulus, so the power-of-two rounding is checked beside the 12 KB slot logic.

// File: rtl/memwin_pkg.sv
package memwin_pkg;

  localparam int ADDR_W = 16;
  localparam int CFG_W  = 8;
  localparam int BASE_W = 5;

  // Stored fields of a placement register
  typedef struct packed {
    logic [BASE_W-1:0] base;  // address bits 15..11
    logic              flag;  // RAM: alignment, EEPROM: enable
  } memwin_cfg_t;

  function automatic memwin_cfg_t cfg_from_byte(input logic [CFG_W-1:0] b);
    memwin_cfg_t c;
    c.base = b[7:3];
    c.flag = b[0];
    return c;
  endfunction

  function automatic logic [CFG_W-1:0] cfg_to_byte(input memwin_cfg_t c);
    return {c.base, 2'b00, c.flag};
  endfunction

  function automatic logic [ADDR_W-1:0] base_addr(input memwin_cfg_t c);
    return {c.base, {(ADDR_W-BASE_W){1'b0}}};
  endfunction

  // Round an address down to a power-of-two size
  function automatic logic [ADDR_W-1:0] align_down(input logic [ADDR_W-1:0] a,
                                                   input logic [ADDR_W-1:0] mask);
    return a & ~mask;
  endfunction

endpackage

// File: rtl/memwin_initreg.sv
module memwin_initreg
  import memwin_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_VAL = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CFG_W-1:0]  din,
  output memwin_cfg_t       cfg,
  output logic [CFG_W-1:0]  rdata
);

  memwin_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= cfg_from_byte(RESET_VAL);
    else if (wr) cfg_q <= cfg_from_byte(din);
  end

  assign cfg   = cfg_q;
  assign rdata = cfg_to_byte(cfg_q);

endmodule

// File: rtl/memwin_ram_window.sv
module memwin_ram_window
  import memwin_pkg::*;
#(
  parameter int RAM_KB = 12,
  parameter int OFF_W  = 14
) (
  input  memwin_cfg_t        cfg,
  input  logic [ADDR_W-1:0]  addr,
  output logic               hit,
  output logic [OFF_W-1:0]   off,
  output logic [ADDR_W-1:0]  win_start
);

  localparam int RAM_BYTES = RAM_KB * 1024;

  generate
    if (RAM_KB == 12) begin : g_slot12
      localparam logic [ADDR_W-1:0] SLOT_MASK = 16'h3FFF;
      localparam logic [13:0]       GAP       = 14'h1000;
      localparam logic [13:0]       SPAN      = 14'h3000;
      logic [ADDR_W-1:0] slot_start;
      logic              in_slot;
      logic [13:0]       slot_off;

      always_comb begin
        slot_start = align_down(base_addr(cfg), SLOT_MASK);
        in_slot    = align_down(addr, SLOT_MASK) == slot_start;
        slot_off   = addr[13:0];
        if (cfg.flag) begin
          hit       = in_slot && (slot_off >= GAP);
          off       = OFF_W'(slot_off - GAP);
          win_start = slot_start | {2'b00, GAP};
        end else begin
          hit       = in_slot && (slot_off < SPAN);
          off       = OFF_W'(slot_off);
          win_start = slot_start;
        end
      end
    end else begin : g_pow2
      localparam logic [ADDR_W-1:0] SIZE_MASK = ADDR_W'(RAM_BYTES - 1);
      always_comb begin
        win_start = align_down(base_addr(cfg), SIZE_MASK);
        hit       = align_down(addr, SIZE_MASK) == win_start;
        off       = addr[OFF_W-1:0];
      end
    end
  endgenerate

endmodule

// File: rtl/memwin_ee_window.sv
module memwin_ee_window
  import memwin_pkg::*;
#(
  parameter int EE_KB = 4,
  parameter int OFF_W = 12
) (
  input  memwin_cfg_t        cfg,
  input  logic [ADDR_W-1:0]  addr,
  output logic               hit,
  output logic [OFF_W-1:0]   off,
  output logic [ADDR_W-1:0]  win_start
);

  localparam int EE_BYTES = EE_KB * 1024;
  localparam logic [ADDR_W-1:0] SIZE_MASK = ADDR_W'(EE_BYTES - 1);

  always_comb begin
    win_start = align_down(base_addr(cfg), SIZE_MASK);
    hit       = cfg.flag && (align_down(addr, SIZE_MASK) == win_start);
    off       = addr[OFF_W-1:0];
  end

endmodule

// File: rtl/memwin_decoder.sv
module memwin_decoder
  import memwin_pkg::*;
#(
  parameter int RAM_KB    = 12,
  parameter int EE_KB     = 4,
  parameter int RAM_OFF_W = $clog2(RAM_KB * 1024),
  parameter int EE_OFF_W  = $clog2(EE_KB * 1024)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_to_ee,
  input  logic [7:0]           wr_data,
  input  logic [15:0]          addr,
  output logic [7:0]           ram_cfg_q,
  output logic [7:0]           ee_cfg_q,
  output logic                 ram_sel,
  output logic [RAM_OFF_W-1:0] ram_off,
  output logic                 ee_sel,
  output logic [EE_OFF_W-1:0]  ee_off
);

  memwin_cfg_t ram_cfg, ee_cfg;
  logic ram_wr, ee_wr;

  // Named internal events for the checker
  logic                 ram_hit, ee_hit, ee_blocked;
  logic [RAM_OFF_W-1:0] ram_raw_off;
  logic [EE_OFF_W-1:0]  ee_raw_off;
  logic [15:0]          ram_start, ee_start;

  assign ram_wr = wr_en && !wr_to_ee;
  assign ee_wr  = wr_en &&  wr_to_ee;

  memwin_initreg #(.RESET_VAL(8'h09)) u_ram_reg (
    .clk(clk), .rst_n(rst_n), .wr(ram_wr), .din(wr_data),
    .cfg(ram_cfg), .rdata(ram_cfg_q)
  );

  memwin_initreg #(.RESET_VAL(8'h00)) u_ee_reg (
    .clk(clk), .rst_n(rst_n), .wr(ee_wr), .din(wr_data),
    .cfg(ee_cfg), .rdata(ee_cfg_q)
  );

  memwin_ram_window #(.RAM_KB(RAM_KB), .OFF_W(RAM_OFF_W)) u_ram_win (
    .cfg(ram_cfg), .addr(addr), .hit(ram_hit), .off(ram_raw_off),
    .win_start(ram_start)
  );

  memwin_ee_window #(.EE_KB(EE_KB), .OFF_W(EE_OFF_W)) u_ee_win (
    .cfg(ee_cfg), .addr(addr), .hit(ee_hit), .off(ee_raw_off),
    .win_start(ee_start)
  );

  // RAM has priority over EEPROM
  assign ee_blocked = ee_hit && ram_hit;
  assign ram_sel    = ram_hit;
  assign ee_sel     = ee_hit && !ee_blocked;
  assign ram_off    = ram_sel ? ram_raw_off : '0;
  assign ee_off     = ee_sel  ? ee_raw_off  : '0;

endmodule

// File: rtl/memwin_checker.sv
module memwin_checker #(
  parameter int RAM_KB    = 12,
  parameter int RAM_OFF_W = 14,
  parameter int EE_OFF_W  = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic                 wr_to_ee,
  input logic [7:0]           wr_data,
  input logic [15:0]          addr,
  input logic [7:0]           ram_cfg_q,
  input logic [7:0]           ee_cfg_q,
  input logic                 ram_sel,
  input logic [RAM_OFF_W-1:0] ram_off,
  input logic                 ee_sel,
  input logic [EE_OFF_W-1:0]  ee_off,
  input logic                 ram_hit,
  input logic                 ee_hit
);

  localparam int RAM_BYTES = RAM_KB * 1024;

  assert_sel_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_sel && ee_sel));

  assert_overlap_ram_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_hit && ee_hit) |-> (ram_sel && !ee_sel));

  assert_ee_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sel |-> ee_cfg_q[0]);

  assert_ram_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_to_ee) |=> (ram_cfg_q == ($past(wr_data) & 8'hF9)));

  assert_ee_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_to_ee) |=> (ee_cfg_q == ($past(wr_data) & 8'hF9)));

  assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(ram_cfg_q) && $stable(ee_cfg_q)));

  assert_ram_off_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sel |-> (int'(ram_off) < RAM_BYTES));

  assert_idle_offsets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((!ram_sel |-> ram_off == '0) and (!ee_sel |-> ee_off == '0)));

  assert_ee_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sel |-> (ee_off == addr[EE_OFF_W-1:0]));

endmodule

bind memwin_decoder memwin_checker #(
  .RAM_KB(RAM_KB), .RAM_OFF_W(RAM_OFF_W), .EE_OFF_W(EE_OFF_W)
) u_memwin_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_to_ee(wr_to_ee),
  .wr_data(wr_data), .addr(addr), .ram_cfg_q(ram_cfg_q), .ee_cfg_q(ee_cfg_q),
  .ram_sel(ram_sel), .ram_off(ram_off), .ee_sel(ee_sel), .ee_off(ee_off),
  .ram_hit(ram_hit), .ee_hit(ee_hit)
);

// File: tb/tb_memwin_decoder.sv
module tb_memwin_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_to_ee = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [15:0] addr = 16'h0000;

  logic [7:0]  ram_cfg_q, ee_cfg_q, s8_ram_cfg_q, s8_ee_cfg_q;
  logic        ram_sel, ee_sel, s8_ram_sel, s8_ee_sel;
  logic [13:0] ram_off;
  logic [11:0] ee_off, s8_ee_off;
  logic [12:0] s8_ram_off;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  memwin_decoder dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_to_ee(wr_to_ee),
    .wr_data(wr_data), .addr(addr), .ram_cfg_q(ram_cfg_q), .ee_cfg_q(ee_cfg_q),
    .ram_sel(ram_sel), .ram_off(ram_off), .ee_sel(ee_sel), .ee_off(ee_off)
  );

  memwin_decoder #(.RAM_KB(8)) dut_s8 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_to_ee(wr_to_ee),
    .wr_data(wr_data), .addr(addr), .ram_cfg_q(s8_ram_cfg_q), .ee_cfg_q(s8_ee_cfg_q),
    .ram_sel(s8_ram_sel), .ram_off(s8_ram_off), .ee_sel(s8_ee_sel), .ee_off(s8_ee_off)
  );

  typedef struct {
    string tag;
    int    a;
    int    rc, ec;
    bit    rs; int ro;
    bit    es; int eo;
    bit    s8s; int s8o;
  } item_t;

  item_t sb[$];
  item_t cur;

  // Model state: what the bench believes the registers hold
  logic [7:0] m_rc = 8'h09;
  logic [7:0] m_ec = 8'h00;

  // RAM window as [lo, hi) from the requirements
  function automatic void ram_span(input logic [7:0] c, input int kb,
                                   output int lo, output int hi);
    int b = int'(c & 8'hF8) * 256;
    if (kb == 12) begin
      lo = b - (b % 16384);
      if (c[0]) lo = lo + 4096;
      hi = lo + 12288;
    end else begin
      lo = b - (b % (kb * 1024));
      hi = lo + kb * 1024;
    end
  endfunction

  task automatic push(input int a, input string tag);
    item_t it;
    int lo, hi, elo;
    it.tag = tag; it.a = a; it.rc = int'(m_rc); it.ec = int'(m_ec);
    ram_span(m_rc, 12, lo, hi);
    it.rs = (a >= lo) && (a < hi);
    it.ro = it.rs ? a - lo : 0;
    elo = int'(m_ec & 8'hF8) * 256;
    elo = elo - (elo % 4096);
    it.es = m_ec[0] && (a >= elo) && (a < elo + 4096) && !it.rs;
    it.eo = it.es ? a - elo : 0;
    ram_span(m_rc, 8, lo, hi);
    it.s8s = (a >= lo) && (a < hi);
    it.s8o = it.s8s ? a - lo : 0;
    sb.push_back(it);
  endtask

  task automatic probe(input int a, input string tag);
    @(posedge clk); #1;
    addr = 16'(a);
    push(a, tag);
  endtask

  // Strobe cycle still expects the old decode, the change lands one edge later
  task automatic write_cfg(input bit to_ee, input logic [7:0] d, input int a, input string tag);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_to_ee = to_ee; wr_data = d; addr = 16'(a);
    push(a, tag);
    @(posedge clk); #1;
    wr_en = 1'b0;
    if (to_ee) m_ec = d & 8'hF9; else m_rc = d & 8'hF9;
    push(a, tag);
  endtask

  task automatic cmp(input string tag, input string what, input int act, input int exp, input int a);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s addr=%h actual=%h expected=%h", tag, what, a, act, exp);
    end
  endtask

  // Monitor: compares each pushed item at the falling edge after it was applied
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      cur = sb.pop_front();
      cmp(cur.tag, "ram_cfg_q", int'(ram_cfg_q), cur.rc, cur.a);
      cmp(cur.tag, "ee_cfg_q",  int'(ee_cfg_q),  cur.ec, cur.a);
      cmp(cur.tag, "ram_sel",   int'(ram_sel),   int'(cur.rs), cur.a);
      cmp(cur.tag, "ram_off",   int'(ram_off),   cur.ro, cur.a);
      cmp(cur.tag, "ee_sel",    int'(ee_sel),    int'(cur.es), cur.a);
      cmp(cur.tag, "ee_off",    int'(ee_off),    cur.eo, cur.a);
      cmp(cur.tag, "s8_ram_sel", int'(s8_ram_sel), int'(cur.s8s), cur.a);
      cmp(cur.tag, "s8_ram_off", int'(s8_ram_off), cur.s8o, cur.a);
    end
  end

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset placement, 12K at 0x1000..0x3FFF, EEPROM off
    probe(16'h0000, "R1");
    probe(16'h1000, "R1");
    // R6 / R10: upper-aligned 12K, address changes each cycle
    probe(16'h0FFF, "R6");
    probe(16'h3FFF, "R6");
    probe(16'h4000, "R6");
    // R2 / R6: lower alignment; R5: alignment has no effect on 8K
    write_cfg(1'b0, 8'h08, 16'h2FFF, "R2");
    probe(16'h3000, "R6");
    probe(16'h0000, "R5");
    // R2: bits 2..1 dropped; R5: low base bits ignored for 8K
    write_cfg(1'b0, 8'h4F, 16'h5000, "R2");
    probe(16'h4FFF, "R6");
    probe(16'h7FFF, "R6");
    probe(16'h4000, "R5");
    probe(16'h5FFF, "R5");
    probe(16'h6000, "R5");
    // R7: 0x39 tops both sizes at 0x3FFF
    write_cfg(1'b0, 8'h39, 16'h3FFF, "R7");
    probe(16'h4000, "R7");
    probe(16'h2000, "R7");
    probe(16'h1000, "R7");
    // Move RAM high, then EEPROM tests
    write_cfg(1'b0, 8'hC1, 16'hD000, "R6");
    probe(16'hFFFF, "R9");
    // R4: base set but disabled
    write_cfg(1'b1, 8'h20, 16'h2000, "R4");
    probe(16'h2FFF, "R4");
    // R3: 0x01 -> 0x0000
    write_cfg(1'b1, 8'h01, 16'h0000, "R3");
    probe(16'h0FFF, "R3");
    probe(16'h1000, "R3");
    // R3: 0x21 -> 0x2000
    write_cfg(1'b1, 8'h21, 16'h2ABC, "R3");
    probe(16'h1FFF, "R3");
    // R3: 0x29 rounds down to 0x2000 for 4K
    write_cfg(1'b1, 8'h2F, 16'h2000, "R3");
    probe(16'h2FFF, "R3");
    probe(16'h3000, "R3");
    // R8: EEPROM inside the RAM window
    write_cfg(1'b1, 8'hD1, 16'hD500, "R8");
    probe(16'hDFFF, "R8");
    // R8 / R9: RAM moved away, EEPROM now selected
    write_cfg(1'b0, 8'h01, 16'hD500, "R8");
    probe(16'hD000, "R9");
    probe(16'hE000, "R9");
    // R2: no strobe, wr_data changes, registers hold
    @(posedge clk); #1 wr_data = 8'hFF; wr_to_ee = 1'b1;
    probe(16'h3FFF, "R2");
    probe(16'hD123, "R2");
    repeat (3) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule